// File: doc/BRIEF.md
# Blank-Gated 16-Bit Timer Channel

This block is one 16-bit timer channel for a video-oriented system. It counts either a prescaled core clock (one step every 2, 32 or 512 cycles) or the rising edges of a horizontal-blank input. It compares the count against a programmable target and wraps at the end of its 16-bit range. On target or wrap it can set a sticky status flag and pulse a single interrupt line.

An optional gate ties counting to the horizontal- or vertical-blank input. A small state machine with four states handles the gate:

- **Free**: ungated; the counter follows its run bit.
- **Wait**: a gate is armed and the counter is stopped at zero.
- **Run**: the gate is open.
- **Hold**: level gate only; the counter is frozen after a blank end.

The transitions are named as follows:

- *cfg-free*: a mode write with no effective gate, from any state to Free.
- *cfg-arm*: a mode write with an effective gate, from any state to Wait.
- *open*: a blank start in level mode, to Run.
- *close*: a blank end in level mode, Run to Hold.
- *restart*: a clearing edge in modes 1 to 3, to Run, with the count cleared.

Software reaches four word registers over a simple write/read bus: mode (offset 0x0), count (0x4), target (0x8) and hold (0xC).

Top module: `blank_gated_timer`

## Requirements
- R1: Clock select (mode bits 1:0) values 0, 1 and 2 advance the count once per 2, 32 and 512 core cycles of enabled counting, with the prescaler restarted by a mode write. Value 3 advances it once per rising edge of `hblank`. Counting also requires the run bit (mode bit 7).
- R2: A mode write loads bits 9:0 from the data. The layout is: ovf_ie=9, tgt_ie=8, run=7, zero_return=6, gate_mode=5:4, gate_src=3, gate_en=2, clk_sel=1:0. Bit 10 (target flag) and bit 11 (overflow flag) are only cleared, and only where the data holds a 1. A mode read returns the live flags in bits 11:10 and zeros above.
- R3: When a step brings an armed target to count >= target with tgt_ie set, the target flag is set and an interrupt is raised. If zero_return is also set, target is subtracted from the count and the target stays armed.
- R4: A target match without tgt_ie, or with tgt_ie but without zero_return, disarms the target until the next wrap. The count keeps running.
- R5: Stepping past 0xFFFF wraps the count to 0 and re-arms the target. With ovf_ie set, the wrap sets the overflow flag and raises an interrupt.
- R6: Gate modes act on edges of the selected blank:
  - 0: counts only while the blank is high, and freezes at its fall.
  - 1: clears and starts at the rise.
  - 2: clears and starts at the fall.
  - 3: clears and starts at both edges.
  - Each clear re-arms the target.
- R7: gate_src 0 selects `hblank` and 1 selects `vblank`. The gate has no effect when gate_src is 0 and clk_sel is 3.
- R8: A mode write with an effective gate clears the count. The counter stays stopped until the first qualifying gate edge.
- R9: A count write loads the low 16 bits and re-arms the target, then disarms it if the new count exceeds the target. The prescaler phase is not disturbed.
- R10: A target write whose value is less than or equal to the current count leaves the target disarmed until the next wrap.
- R11: `irq` is a one-cycle pulse, registered one cycle after the event. Coincident target and wrap events give a single pulse and set both flags.
- R12: Reset values are: mode 0, count 0, target 0xFFFF (armed), hold 0. The hold register reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte offset; bits 3:2 pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| hblank | input | 1 | Horizontal-blank level |
| vblank | input | 1 | Vertical-blank level |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench targets the corner cases below. In each case, a faulty design shows a visible symptom:

- **Prescaler phase across a count write.** A design that restarts the prescaler on that write slips its next step by a whole period.
- **Wrap re-arming a target that a count write disarmed.** A design that forgets to disarm fires on the stale target. One that forgets to re-arm never fires after the wrap.
- **Level gate.** It must resume from its frozen value rather than zero, which separates it from the clearing modes. The bench checks each clearing mode on the edges it must ignore as well as on those it must obey.
- **Gate source and clock source interlock.** The bench checks the case where the gate must be ignored.
- **Write-one-to-clear flags under random mode writes.** A design that lets software set a flag shows that flag on readback.

// File: rtl/bgt_pkg.sv
package bgt_pkg;

    typedef enum logic [1:0] {
        GT_FREE,
        GT_WAIT,
        GT_RUN,
        GT_HOLD
    } gate_state_t;

    typedef enum logic [1:0] {
        GM_LEVEL = 2'd0,
        GM_START = 2'd1,
        GM_END   = 2'd2,
        GM_BOTH  = 2'd3
    } gate_mode_t;

    typedef enum logic [1:0] {
        RS_MODE   = 2'd0,
        RS_COUNT  = 2'd1,
        RS_TARGET = 2'd2,
        RS_HOLD   = 2'd3
    } reg_sel_t;

    // Writable part of the mode word, most significant field first (bit 9 down to bit 0).
    typedef struct packed {
        logic       ovf_ie;
        logic       tgt_ie;
        logic       run;
        logic       zret;
        gate_mode_t gmode;
        logic       gsrc;
        logic       gen;
        logic [1:0] csel;
    } mode_cfg_t;

    localparam int CFG_W   = $bits(mode_cfg_t);
    localparam int FLAG_LO = CFG_W;
    localparam logic [1:0] CSEL_HBLANK = 2'd3;

endpackage

// File: rtl/bgt_prescaler.sv
module bgt_prescaler #(
    parameter int DIV0 = 2,
    parameter int DIV1 = 32,
    parameter int DIV2 = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       adv,
    input  logic [1:0] sel,
    output logic       wrap
);
    localparam int PW = $clog2(DIV2);

    logic [PW-1:0] phase;
    logic [PW-1:0] lim;

    always_comb begin
        unique case (sel)
            2'd1:    lim = PW'(DIV1 - 1);
            2'd2:    lim = PW'(DIV2 - 1);
            default: lim = PW'(DIV0 - 1);
        endcase
    end

    assign wrap = adv && (phase == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart) begin
            phase <= '0;
        end else if (adv) begin
            phase <= wrap ? '0 : phase + 1'b1;
        end
    end

    // R1: two prescaled steps are never adjacent, since every divisor is at least 2
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> !wrap);

endmodule

// File: rtl/bgt_gate_fsm.sv
module bgt_gate_fsm
    import bgt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       new_gated,
    input  gate_mode_t gmode,
    input  logic       gsrc,
    input  logic       hb_rise,
    input  logic       hb_fall,
    input  logic       vb_rise,
    input  logic       vb_fall,
    output logic       gate_open,
    output logic       gate_clr
);
    gate_state_t st_q, st_d;
    logic e_rise, e_fall;

    assign e_rise = gsrc ? vb_rise : hb_rise;
    assign e_fall = gsrc ? vb_fall : hb_fall;

    // next state and the clear strobe
    always_comb begin
        st_d     = st_q;
        gate_clr = 1'b0;
        if (cfg_wr) begin
            st_d = new_gated ? GT_WAIT : GT_FREE;
        end else if (st_q != GT_FREE) begin
            if (e_rise) begin
                unique case (gmode)
                    GM_LEVEL:         st_d = GT_RUN;
                    GM_START, GM_BOTH: begin
                        st_d     = GT_RUN;
                        gate_clr = 1'b1;
                    end
                    default:          st_d = st_q;
                endcase
            end else if (e_fall) begin
                unique case (gmode)
                    GM_LEVEL:         st_d = GT_HOLD;
                    GM_END, GM_BOTH: begin
                        st_d     = GT_RUN;
                        gate_clr = 1'b1;
                    end
                    default:          st_d = st_q;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GT_FREE;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            GT_FREE, GT_RUN:  gate_open = 1'b1;
            GT_WAIT, GT_HOLD: gate_open = 1'b0;
            default:          gate_open = 1'b0;
        endcase
    end

    assert_cfg_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !new_gated) |=> (st_q == GT_FREE));
    assert_cfg_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && new_gated) |=> (st_q == GT_WAIT));
    assert_hold_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == GT_HOLD) |-> (gmode == GM_LEVEL));
    assert_clear_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        gate_clr |=> (st_q == GT_RUN));

endmodule

// File: rtl/bgt_cmp_wrap.sv
module bgt_cmp_wrap #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] tgt,
    input  logic          armed,
    input  logic          tick,
    input  logic          tgt_ie,
    input  logic          ovf_ie,
    input  logic          zret,
    output logic [CW-1:0] cnt_nx,
    output logic          armed_nx,
    output logic          tgt_evt,
    output logic          ovf_evt
);
    logic [CW:0] adv;
    logic [CW:0] after_t;

    always_comb begin
        adv      = {1'b0, cnt} + (CW+1)'(tick);
        after_t  = adv;
        armed_nx = armed;
        tgt_evt  = 1'b0;
        ovf_evt  = 1'b0;
        if (tick && armed && (adv >= {1'b0, tgt})) begin
            tgt_evt = tgt_ie;
            if (tgt_ie && zret) after_t = adv - {1'b0, tgt};
            else                armed_nx = 1'b0;
        end
        if (after_t[CW]) begin
            armed_nx = 1'b1;
            ovf_evt  = ovf_ie;
        end
        cnt_nx = after_t[CW-1:0];
    end

endmodule

// File: rtl/blank_gated_timer.sv
module blank_gated_timer
    import bgt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DW    = 32,
    parameter int DIV0  = 2,
    parameter int DIV1  = 32,
    parameter int DIV2  = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [3:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          hblank,
    input  logic          vblank,
    output logic          irq
);
    localparam int FLAG_W = 2;
    localparam int PAD_W  = DW - CFG_W - FLAG_W;
    localparam int CPAD_W = DW - CNT_W;

    mode_cfg_t         cfg, wr_cfg;
    logic [FLAG_W-1:0] flags;         // [0] target reached, [1] overflow reached
    logic [CNT_W-1:0]  count, target, hold;
    logic              armed;
    logic              hb_q, vb_q;
    reg_sel_t          rsel;
    logic              wr_mode, wr_count, wr_target, wr_hold;
    logic              new_gated, active, gate_open, gate_clr;
    logic              pre_wrap, tick;
    logic [CNT_W-1:0]  cnt_nx, cnt_d, wval;
    logic              armed_nx, arm_d, use_cmp;
    logic              tgt_evt, ovf_evt, tgt_fire, ovf_fire;
    logic              hb_rise, hb_fall, vb_rise, vb_fall;
    logic              unused_bits;

    assign unused_bits = ^{bus_wdata[DW-1:FLAG_LO+FLAG_W], bus_addr[1:0]};

    assign rsel      = reg_sel_t'(bus_addr[3:2]);
    assign wr_mode   = bus_wr && (rsel == RS_MODE);
    assign wr_count  = bus_wr && (rsel == RS_COUNT);
    assign wr_target = bus_wr && (rsel == RS_TARGET);
    assign wr_hold   = bus_wr && (rsel == RS_HOLD);
    assign wval      = bus_wdata[CNT_W-1:0];
    assign wr_cfg    = mode_cfg_t'(bus_wdata[CFG_W-1:0]);
    assign new_gated = wr_cfg.gen && !(!wr_cfg.gsrc && (wr_cfg.csel == CSEL_HBLANK));

    assign hb_rise = hblank & ~hb_q;
    assign hb_fall = ~hblank & hb_q;
    assign vb_rise = vblank & ~vb_q;
    assign vb_fall = ~vblank & vb_q;

    bgt_gate_fsm u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (wr_mode),
        .new_gated (new_gated),
        .gmode     (cfg.gmode),
        .gsrc      (cfg.gsrc),
        .hb_rise   (hb_rise),
        .hb_fall   (hb_fall),
        .vb_rise   (vb_rise),
        .vb_fall   (vb_fall),
        .gate_open (gate_open),
        .gate_clr  (gate_clr)
    );

    assign active = cfg.run && gate_open;

    bgt_prescaler #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_mode || gate_clr),
        .adv     (active && (cfg.csel != CSEL_HBLANK)),
        .sel     (cfg.csel),
        .wrap    (pre_wrap)
    );

    assign tick = active && ((cfg.csel == CSEL_HBLANK) ? hb_rise : pre_wrap);

    bgt_cmp_wrap #(.CW(CNT_W)) u_cmp (
        .cnt      (count),
        .tgt      (target),
        .armed    (armed),
        .tick     (tick),
        .tgt_ie   (cfg.tgt_ie),
        .ovf_ie   (cfg.ovf_ie),
        .zret     (cfg.zret),
        .cnt_nx   (cnt_nx),
        .armed_nx (armed_nx),
        .tgt_evt  (tgt_evt),
        .ovf_evt  (ovf_evt)
    );

    // next count and arm state: count write beats gate clear beats gate enable beats stepping
    always_comb begin
        cnt_d   = cnt_nx;
        arm_d   = armed_nx;
        use_cmp = 1'b1;
        if (wr_count) begin
            cnt_d   = wval;
            arm_d   = !(wval > target);
            use_cmp = 1'b0;
        end else if (gate_clr) begin
            cnt_d   = '0;
            arm_d   = 1'b1;
            use_cmp = 1'b0;
        end else if (wr_mode && new_gated) begin
            cnt_d   = '0;
            arm_d   = armed;
            use_cmp = 1'b0;
        end
        if (wr_target) arm_d = (wval > cnt_d);
    end

    assign tgt_fire = tgt_evt && use_cmp;
    assign ovf_fire = ovf_evt && use_cmp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg    <= '0;
            flags  <= '0;
            count  <= '0;
            target <= '1;
            hold   <= '0;
            armed  <= 1'b1;
            hb_q   <= 1'b0;
            vb_q   <= 1'b0;
            irq    <= 1'b0;
        end else begin
            hb_q  <= hblank;
            vb_q  <= vblank;
            count <= cnt_d;
            armed <= arm_d;
            irq   <= tgt_fire || ovf_fire;
            flags <= (flags & ~(wr_mode ? bus_wdata[FLAG_LO +: FLAG_W] : '0))
                     | {ovf_fire, tgt_fire};
            if (wr_mode)   cfg    <= wr_cfg;
            if (wr_target) target <= wval;
            if (wr_hold)   hold   <= wval;
        end
    end

    always_comb begin
        unique case (rsel)
            RS_MODE:   bus_rdata = {{PAD_W{1'b0}}, flags, cfg};
            RS_COUNT:  bus_rdata = {{CPAD_W{1'b0}}, count};
            RS_TARGET: bus_rdata = {{CPAD_W{1'b0}}, target};
            default:   bus_rdata = {{CPAD_W{1'b0}}, hold};
        endcase
    end

    assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_w1c_no_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && !tgt_fire && !ovf_fire) |=> ((flags & ~$past(flags)) == '0));
    assert_tgt_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_fire |=> (flags[0] && irq));
    assert_ovf_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_fire |=> (flags[1] && irq));
    assert_gate_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && new_gated) |=> (count == '0));
    assert_count_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count |=> (count == $past(wval)));

endmodule

// File: tb/blank_gated_timer_tb.sv
module blank_gated_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        hblank = 1'b0;
    logic        vblank = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [3:0] A_MODE = 4'h0, A_CNT = 4'h4, A_TGT = 4'h8, A_HOLD = 4'hC;

    blank_gated_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hblank(hblank), .vblank(vblank), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] mk(int csel, int gen, int gsrc, int gm,
                                       int zret, int run, int tie, int oie);
        return 32'((oie << 9) | (tie << 8) | (run << 7) | (zret << 6) |
                   (gm << 4) | (gsrc << 3) | (gen << 2) | csel);
    endfunction

    function automatic int exp_steps(int k, int sel);
        return k >> (1 + 4 * sel);
    endfunction

    function automatic bit exp_armed(int c, int t);
        return t > c;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // index (1-based) of the first negedge with irq high, 0 if none
    task automatic wait_irq(int maxc, output int seen);
        seen = 0;
        for (int i = 1; i <= maxc; i++) begin
            step(1);
            if (irq && seen == 0) begin
                seen = i;
                break;
            end
        end
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int seen;
        void'($urandom(32'd4242));
        step(3);
        rst_n = 1'b1;
        step(1);

        // R12 reset values and hold storage
        rd(A_MODE, d); check("R12 mode reset", d, 32'h0);
        rd(A_CNT, d);  check("R12 count reset", d, 32'h0);
        rd(A_TGT, d);  check("R12 target reset", d, 32'hFFFF);
        rd(A_HOLD, d); check("R12 hold reset", d, 32'h0);
        wr(A_HOLD, 32'h1234_A5C3);
        rd(A_HOLD, d); check("R12 hold readback", d, 32'hA5C3);

        // R2 flags cannot be set by software
        wr(A_MODE, 32'hC7F);
        rd(A_MODE, d); check("R2 flags not settable", d, 32'h07F);
        wr(A_MODE, 32'h0);

        // R3 target with interrupt and zero return
        wr(A_TGT, 32'd5); wr(A_CNT, 32'd0);
        wr(A_MODE, mk(0, 0, 0, 0, 1, 1, 1, 0));
        wait_irq(30, seen);
        check("R3 target irq cycle", seen, 10);
        rd(A_CNT, d); check("R3 zero return count", d, 32'd0);
        rd(A_MODE, d); check("R3 target flag", d[11:10], 2'b01);
        step(1);
        check("R11 irq one cycle", irq, 1'b0);
        wr(A_MODE, 32'h400);
        rd(A_MODE, d); check("R2 w1c clears target flag", d, 32'h0);

        // R11 pulses per event with target 0 and zero return
        wr(A_TGT, 32'd0); wr(A_CNT, 32'd0);
        wr(A_MODE, mk(0, 0, 0, 0, 1, 1, 1, 0));
        begin
            int mism = 0;
            for (int i = 1; i <= 6; i++) begin
                step(1);
                if (irq !== ((i % 2) == 0)) mism++;
            end
            check("R11 pulse pattern", mism, 0);
        end
        wr(A_MODE, 32'h0); wr(A_MODE, 32'hC00);

        // R4 match without zero return disarms, count keeps going
        wr(A_TGT, 32'd3); wr(A_CNT, 32'd0);
        wr(A_MODE, mk(0, 0, 0, 0, 0, 1, 1, 0));
        wait_irq(20, seen);
        check("R4 first match cycle", seen, 6);
        rd(A_CNT, d); check("R4 count at match", d, 32'd3);
        step(10);
        rd(A_CNT, d); check("R4 count continues", d, 32'd8);
        wait_irq(20, seen);
        check("R4 no second match", seen, 0);

        // R9 count above target disarms; R5 wrap re-arms and flags
        wr(A_MODE, 32'hC00);
        wr(A_TGT, 32'h10); wr(A_CNT, 32'hFFFE);
        wr(A_MODE, mk(0, 0, 0, 0, 0, 1, 1, 1));
        wait_irq(10, seen);
        check("R5 wrap irq cycle", seen, 4);
        rd(A_CNT, d); check("R5 wrap to zero", d, 32'd0);
        rd(A_MODE, d); check("R9 stale target silent", d[11:10], 2'b10);
        wait_irq(40, seen);
        check("R5 re-armed target cycle", seen, 32);
        rd(A_CNT, d); check("R5 count at re-armed match", d, 32'h10);
        rd(A_MODE, d); check("R5 both flags", d[11:10], 2'b11);

        // R10 target equal to count is disarmed
        wr(A_MODE, 32'hC00);
        wr(A_CNT, 32'h20); wr(A_TGT, 32'h20);
        wr(A_MODE, mk(0, 0, 0, 0, 0, 1, 1, 0));
        wait_irq(40, seen);
        check("R10 no match", seen, 0);
        rd(A_CNT, d); check("R10 count ran", d, 32'h34);

        // R9 prescaler phase survives a count write
        wr(A_MODE, 32'hC00); wr(A_CNT, 32'd0);
        wr(A_MODE, mk(1, 0, 0, 0, 0, 1, 0, 0));
        step(20);
        wr(A_CNT, 32'h100);
        step(10);
        rd(A_CNT, d); check("R9 before phase step", d, 32'h100);
        step(1);
        rd(A_CNT, d); check("R9 phase kept", d, 32'h101);

        // R6/R8 gate mode 1 on vblank
        wr(A_MODE, mk(0, 1, 1, 1, 0, 1, 0, 0));
        step(10);
        rd(A_CNT, d); check("R8 gated wait stopped", d, 32'd0);
        vblank = 1'b1; step(11);
        rd(A_CNT, d); check("R6 mode1 after rise", d, 32'd5);
        vblank = 1'b0; step(10);
        rd(A_CNT, d); check("R6 mode1 ignores fall", d, 32'd10);

        // R6 gate mode 0 (level)
        wr(A_MODE, mk(0, 1, 1, 0, 0, 1, 0, 0));
        vblank = 1'b1; step(10);
        rd(A_CNT, d); check("R6 mode0 counting", d, 32'd4);
        vblank = 1'b0; step(10);
        rd(A_CNT, d); check("R6 mode0 frozen", d, 32'd5);
        vblank = 1'b1; step(5);
        rd(A_CNT, d); check("R6 mode0 resumes", d, 32'd7);

        // R6 gate mode 2
        wr(A_MODE, mk(0, 1, 1, 2, 0, 1, 0, 0));
        vblank = 1'b0; step(7);
        rd(A_CNT, d); check("R6 mode2 after fall", d, 32'd3);
        vblank = 1'b1; step(4);
        rd(A_CNT, d); check("R6 mode2 ignores rise", d, 32'd5);
        vblank = 1'b0; step(1);
        rd(A_CNT, d); check("R6 mode2 clears on fall", d, 32'd0);

        // R6 gate mode 3
        wr(A_MODE, mk(0, 1, 1, 3, 0, 1, 0, 0));
        vblank = 1'b1; step(9);
        rd(A_CNT, d); check("R6 mode3 after rise", d, 32'd4);
        vblank = 1'b0; step(1);
        rd(A_CNT, d); check("R6 mode3 clears on fall", d, 32'd0);

        // R7/R1 hblank clock with hblank gate: gate ignored
        wr(A_MODE, mk(3, 1, 0, 1, 0, 1, 0, 0));
        wr(A_CNT, 32'd0);
        for (int p = 0; p < 5; p++) begin
            hblank = 1'b1; vblank = (p == 2); step(1);
            hblank = 1'b0; vblank = 1'b0; step(1);
        end
        rd(A_CNT, d); check("R7 gate ignored, R1 hblank clock", d, 32'd5);

        // R7 source select: hblank gate ignores vblank edges
        wr(A_MODE, mk(0, 1, 0, 1, 0, 1, 0, 0));
        vblank = 1'b1; step(3); vblank = 1'b0; step(3);
        rd(A_CNT, d); check("R7 vblank ignored by hblank gate", d, 32'd0);
        hblank = 1'b1; step(11);
        rd(A_CNT, d); check("R7 hblank rise starts", d, 32'd5);
        hblank = 1'b0;
        wr(A_MODE, 32'hC00);

        // R1 random prescale checks
        for (int it = 0; it < 10; it++) begin
            int sel = int'($urandom % 3);
            int k = int'($urandom % 1200) + 1;
            wr(A_MODE, 32'h0); wr(A_CNT, 32'd0);
            wr(A_MODE, mk(sel, 0, 0, 0, 0, 1, 0, 0));
            step(k);
            rd(A_CNT, d);
            check("R1 random prescale", d, 32'(exp_steps(k, sel)));
        end

        // R2 random mode writes with interrupts off
        for (int it = 0; it < 16; it++) begin
            logic [31:0] v = $urandom;
            logic [9:0] low = v[9:0] & ~10'h300;
            wr(A_MODE, {20'h0, v[11:10], low});
            rd(A_MODE, d);
            check("R2 random mode readback", d, {22'h0, low});
        end

        // R9/R10 random count and target pairs
        for (int it = 0; it < 12; it++) begin
            int c = int'($urandom_range(16, 32'hFFE0));
            int t = c + int'($urandom % 7) - 3;
            wr(A_MODE, 32'hC00);
            wr(A_CNT, 32'(c)); wr(A_TGT, 32'(t));
            wr(A_MODE, mk(0, 0, 0, 0, 0, 1, 1, 0));
            wait_irq(20, seen);
            check("R10 random arm", (seen != 0), exp_armed(c, t));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule